// File: doc/BRIEF.md
# Host Video Memory Access Port

This block sits between a host processor and a 128KB byte-wide video memory. The host reaches the memory through two byte ports. The control port takes address setup and register writes. The data port moves one byte per access to or from the current address. Each data access advances the address, so a host can stream a run of bytes after a single setup.

An address setup takes two control writes. The first write gives the low eight bits of the address. The second write gives the next six bits and a direction bit. Three further address bits sit in a separate high register. The host loads that register with a control-port register write. If the host never writes the high register, the port behaves as a plain 14-bit, 16KB interface.

Read setups and data reads go through a one-byte read buffer. A read setup fetches the addressed byte ahead of time. Each data read returns the buffered byte and then fetches the next one. Memory traffic runs as single-byte requests under a valid/ready handshake. The host is held off while a request is outstanding.

Top module: `vram_host_port`

## Requirements
- R1: After reset, no memory request is pending and `cpu_busy` is low. The high address register is zero, and the control port expects a first byte.
- R2: An address setup is two control writes. The first byte gives address bits 7:0. In the second byte, bits 5:0 give address bits 13:8, bit 7 is 0, and bit 6 is the direction (1 write, 0 read).
- R3: A second control byte with bit 7 set and bits 5:0 equal to 14 loads bits 2:0 of the preceding first byte into the high register. The high register supplies address bits 16:14.
- R4: A second control byte with bit 7 set and any other register number changes neither the 14-bit address nor the high register.
- R5: A data-port write issues one memory write of that byte at the current 17-bit address. The address then advances by one.
- R6: A read setup (bit 6 = 0) issues one memory read at the new address. A write setup issues no memory request.
- R7: A data-port read returns the buffered byte, advances the address, and issues a memory read at the advanced address.
- R8: A carry out of address bit 13 increments the high register. The full 17-bit address wraps from 0x1FFFF to 0x00000.
- R9: Any control-port read returns the control port to the first-byte state.
- R10: While a memory request is outstanding, `cpu_busy` is high and the request's address, direction and data stay stable until `mem_ready`. No host access is accepted during that time.
- R11: With the high register left at zero after reset, a setup addresses the legacy 16KB range: `mem_addr` bits 16:14 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Host access strobe; accepted when `cpu_busy` is low |
| cpu_ctrl | input | 1 | 1 selects the control port, 0 the data port |
| cpu_we | input | 1 | 1 for a host write, 0 for a host read |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Host read byte, valid the cycle after acceptance |
| cpu_busy | output | 1 | A memory request is outstanding |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 8 | Memory read byte |

## Verification
A wrong internal state in this block shows up at the ports in one of three ways. A corrupted address, high register or byte toggle appears on `mem_addr` at the very next memory request. A stale or misfilled read buffer appears on `cpu_rdata` at the next data read. A missed carry into the high register appears as soon as a run of accesses crosses a 16KB boundary. The sweep covers every high-register value, combined with low addresses at the bottom, middle and top of a 16KB window, and with memory latencies of zero to two cycles. This drives both carry and wrap, and each write is read back through the prefetch path.

// File: rtl/vram_host_port.sv
module vram_host_port #(
  parameter int HI_W   = 3,
  parameter int HI_REG = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_ctrl,
  input  logic                 cpu_we,
  input  logic [7:0]           cpu_wdata,
  output logic [7:0]           cpu_rdata,
  output logic                 cpu_busy,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [14+HI_W-1:0]   mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic                 mem_ready,
  input  logic [7:0]           mem_rdata
);
  localparam int LO_W = 14;
  localparam int AW   = LO_W + HI_W;

  logic            second_q;
  logic [7:0]      low_q;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      rbuf_q;
  logic [7:0]      rdata_q;
  logic            valid_q;
  logic            we_q;
  logic [AW-1:0]   addr_q;
  logic [7:0]      wdata_q;

  logic [AW-1:0] cur_addr;
  logic [AW-1:0] nxt_addr;
  logic          accept;

  assign cur_addr  = {hi_q, lo_q};
  assign nxt_addr  = cur_addr + AW'(1);
  assign accept    = cpu_req & ~valid_q;

  assign cpu_rdata = rdata_q;
  assign cpu_busy  = valid_q;
  assign mem_valid = valid_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      low_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      rbuf_q   <= '0;
      rdata_q  <= '0;
      valid_q  <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      if (valid_q && mem_ready) begin
        valid_q <= 1'b0;
        if (!we_q) rbuf_q <= mem_rdata;
      end
      if (accept) begin
        if (cpu_ctrl) begin
          if (!cpu_we) begin
            second_q <= 1'b0;
            rdata_q  <= '0;
          end else if (!second_q) begin
            low_q    <= cpu_wdata;
            second_q <= 1'b1;
          end else begin
            second_q <= 1'b0;
            if (!cpu_wdata[7]) begin
              lo_q <= {cpu_wdata[5:0], low_q};
              if (!cpu_wdata[6]) begin
                valid_q <= 1'b1;
                we_q    <= 1'b0;
                addr_q  <= {hi_q, cpu_wdata[5:0], low_q};
              end
            end else if (cpu_wdata[5:0] == 6'(HI_REG)) begin
              hi_q <= low_q[HI_W-1:0];
            end
          end
        end else begin
          {hi_q, lo_q} <= nxt_addr;
          valid_q      <= 1'b1;
          we_q         <= cpu_we;
          if (cpu_we) begin
            addr_q  <= cur_addr;
            wdata_q <= cpu_wdata;
          end else begin
            addr_q  <= nxt_addr;
            rdata_q <= rbuf_q;
          end
        end
      end
    end
  end
endmodule

module vram_host_port_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_ctrl,
  input logic          cpu_we,
  input logic [7:0]    cpu_wdata,
  input logic [7:0]    cpu_rdata,
  input logic          cpu_busy,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ready,
  input logic [AW-1:0] cur_addr,
  input logic [7:0]    rbuf,
  input logic          second
);
  logic acc_data, acc_ctrl_rd;
  assign acc_data    = cpu_req && !cpu_busy && !cpu_ctrl;
  assign acc_ctrl_rd = cpu_req && !cpu_busy && cpu_ctrl && !cpu_we;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !mem_valid && !cpu_busy);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R5
  wr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && cpu_we |=> mem_valid && mem_we && mem_wdata == $past(cpu_wdata) && mem_addr == $past(cur_addr));

  // R7
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && !cpu_we |=> mem_valid && !mem_we && cpu_rdata == $past(rbuf) && mem_addr == $past(cur_addr) + AW'(1));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data |=> cur_addr == $past(cur_addr) + AW'(1));

  // R9
  toggle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ctrl_rd |=> !second);
endmodule

bind vram_host_port vram_host_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ctrl(cpu_ctrl), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .cur_addr(cur_addr), .rbuf(rbuf_q), .second(second_q)
);

// File: tb/vram_host_port_tb.sv
module vram_host_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_ctrl = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_busy, mem_valid, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0, failures = 0, lat = 0, wait_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  logic [16:0] last_wa = '0, last_ra = '0;
  logic [7:0]  last_wd = '0;
  logic [7:0]  mem [int];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ctrl(cpu_ctrl), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pattern(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {a[16], 7'h25};
  endfunction

  function automatic logic [7:0] lookup(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return pattern(a);
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      if (wait_cnt >= lat) begin
        mem_ready = 1'b1;
        mem_rdata = lookup(mem_addr);
      end
      wait_cnt++;
    end else begin
      mem_ready = 1'b0;
      wait_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[int'(mem_addr)] = mem_wdata;
        last_wa = mem_addr;
        last_wd = mem_wdata;
        wr_cnt++;
      end else begin
        last_ra = mem_addr;
        rd_cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic ctrl, input logic we, input logic [7:0] d);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    cpu_req = 1'b1; cpu_ctrl = ctrl; cpu_we = we; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
  endtask

  task automatic setup(input logic [16:0] a, input logic wr);
    acc(1'b1, 1'b1, {5'b0, a[16:14]});
    acc(1'b1, 1'b1, 8'h8E);
    acc(1'b1, 1'b1, a[7:0]);
    acc(1'b1, 1'b1, {1'b0, wr, a[13:8]});
  endtask

  task automatic data_rd(output logic [7:0] v);
    acc(1'b0, 1'b0, 8'h00);
    v = cpu_rdata;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [7:0]  v;
    logic [16:0] base;
    int          rc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mem_valid", 32'(mem_valid), 0);
    check("R1 cpu_busy", 32'(cpu_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 legacy addressing: only the two-byte setup, high register untouched
    acc(1'b1, 1'b1, 8'hBC);
    acc(1'b1, 1'b1, 8'h7A);
    acc(1'b0, 1'b1, 8'h5A);
    idle();
    check("R11 legacy addr", 32'(last_wa), 32'h03ABC);
    check("R5 legacy data", 32'(last_wd), 32'h5A);

    // R2 R3 R5 R6 R7 R8 sweep over every high value and edge low addresses
    for (int h = 0; h < 8; h++) begin
      for (int i = 0; i < 5; i++) begin
        logic [13:0] lo;
        logic [7:0]  b0, b1;
        case (i)
          0: lo = 14'h0000;
          1: lo = 14'h0001;
          2: lo = 14'h155A;
          3: lo = 14'h3FFE;
          default: lo = 14'h3FFF;
        endcase
        lat  = (h + i) % 3;
        base = {3'(h), lo};
        b0   = 8'(h * 37 + i * 11 + 1);
        b1   = ~b0;
        rc   = rd_cnt;
        setup(base, 1'b1);
        idle();
        check("R6 no fetch on write setup", 32'(rd_cnt), 32'(rc));
        acc(1'b0, 1'b1, b0);
        idle();
        check("R5 write addr", 32'(last_wa), 32'(base));
        acc(1'b0, 1'b1, b1);
        idle();
        check("R8 write addr step", 32'(last_wa), 32'(17'(base + 17'd1)));
        setup(base, 1'b0);
        idle();
        check("R6 prefetch addr", 32'(last_ra), 32'(base));
        check("R6 one prefetch", 32'(rd_cnt), 32'(rc + 1));
        data_rd(v);
        check("R7 read byte 0", 32'(v), 32'(b0));
        idle();
        check("R7 refetch addr", 32'(last_ra), 32'(17'(base + 17'd1)));
        data_rd(v);
        check("R7 read byte 1", 32'(v), 32'(b1));
        idle();
        check("R8 refetch after two", 32'(last_ra), 32'(17'(base + 17'd2)));
      end
    end

    // R7 read of an unwritten location returns memory content
    lat = 1;
    setup(17'h0A0F0, 1'b0);
    data_rd(v);
    check("R7 unwritten read", 32'(v), 32'(pattern(17'h0A0F0)));

    // R3 high register load from low bits of the first byte
    acc(1'b1, 1'b1, 8'hFD);
    acc(1'b1, 1'b1, 8'h8E);
    acc(1'b1, 1'b1, 8'h20);
    acc(1'b1, 1'b1, 8'h41);
    acc(1'b0, 1'b1, 8'h11);
    idle();
    check("R3 high reg addr", 32'(last_wa), 32'h14120);

    // R4 register write to another number leaves address and high register
    setup(17'h00100, 1'b1);
    acc(1'b1, 1'b1, 8'h07);
    acc(1'b1, 1'b1, 8'h85);
    acc(1'b0, 1'b1, 8'h22);
    idle();
    check("R4 address kept", 32'(last_wa), 32'h00100);

    // R9 control read resets the toggle after a lone first byte
    setup(17'h00200, 1'b1);
    acc(1'b1, 1'b1, 8'h33);
    acc(1'b1, 1'b0, 8'h00);
    acc(1'b1, 1'b1, 8'h10);
    acc(1'b1, 1'b1, 8'h42);
    acc(1'b0, 1'b1, 8'h44);
    idle();
    check("R9 toggle reset", 32'(last_wa), 32'h00210);

    // R10 stall with slow memory
    lat = 4;
    rc = wr_cnt;
    setup(17'h02000, 1'b1);
    acc(1'b0, 1'b1, 8'h66);
    check("R10 busy while pending", 32'(cpu_busy), 1);
    check("R10 request held", 32'(mem_addr), 32'h02000);
    acc(1'b0, 1'b1, 8'h67);
    idle();
    check("R10 one handshake each", 32'(wr_cnt), 32'(rc + 2));
    check("R10 second after stall", 32'(last_wa), 32'h02001);
    check("R10 second data", 32'(last_wd), 32'h67);

    done = 1;
    summary();
  end
endmodule